// File: doc/BRIEF.md
# Instruction exception entry sequencer

This block works next to the decode stage of a simple 32-bit processor. For every decoded instruction it gets a set of decode flags: undefined, delayed branch, PC-writing and trap. It also gets the trap vector number, the current PC and status word, the address of the next instruction and the branch target. It keeps its own record of whether the instruction now being decoded sits in the slot behind a delayed branch. From these inputs it picks one of three instruction exceptions: a trap, an illegal instruction in a delay slot, or a general illegal instruction.

Once an exception is picked, the block stalls decode and runs the entry sequence on a memory port. It pushes the status word, then pushes the return PC, with the stack pointer pre-decremented by 4 before each 32-bit push. It then reads the handler address from the vector table at `vbase_i + vector*4`. Finally, in a single cycle, it loads the new PC and the new stack pointer and pulses a done flag. The jump to the handler is not delayed, so no instruction runs between the entry sequence and the handler.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, stall_o, mem_req_o, done_o, pc_load_o and sp_wr_o are low and the delay-slot record is clear. An undefined instruction decoded first is treated as a general illegal instruction.
- R2: An entry makes exactly three memory accesses, in this order. The first writes the status word to sp_i-4. The second writes the return PC to sp_i-8. The third reads (mem_we_o low) from vbase_i + 4*vector. The first access starts in the cycle after detection.
- R3: A trap that is not in a delay slot stacks next_pc_i and uses vector dec_trap_vec_i.
- R4: An instruction decoded in a delay slot with any of undefined, delayed branch, PC-writing or trap set raises the slot exception. This takes priority over the other two exceptions. It uses vector SLOT_VEC (default 6) and stacks the br_target_i value sampled when the preceding delayed branch was decoded.
- R5: An undefined instruction outside a delay slot uses vector ILL_VEC (default 4) and stacks its own address cur_pc_i.
- R6: The delay-slot record covers exactly one accepted instruction after a delayed branch that raised no exception. Exception entry clears it.
- R7: In the cycle after the vector read is acknowledged, done_o, pc_load_o and sp_wr_o pulse for one cycle. In that cycle pc_o equals the data read and sp_o equals sp_i-8.
- R8: stall_o is high from the detection cycle through the done cycle. dec_valid_i has no effect while the block is stalled.
- R9: While mem_req_o is high and mem_ack_i is low, the request and its address stay unchanged into the next cycle.
- R10: An accepted instruction that raises no exception does not assert stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A decoded instruction is presented |
| dec_undef_i | input | 1 | Instruction is undefined |
| dec_dbranch_i | input | 1 | Instruction is a delayed branch |
| dec_pc_wr_i | input | 1 | Instruction writes the PC |
| dec_trap_i | input | 1 | Instruction is a trap |
| dec_trap_vec_i | input | 8 | Vector number of the trap |
| cur_pc_i | input | 32 | Address of the decoded instruction |
| cur_sr_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the following instruction |
| br_target_i | input | 32 | Target of a delayed branch being decoded |
| sp_i | input | 32 | Current stack pointer |
| vbase_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack on a read |
| stall_o | output | 1 | Hold the decode stage |
| pc_load_o | output | 1 | Load pc_o into the PC |
| pc_o | output | 32 | Handler address |
| sp_wr_o | output | 1 | Load sp_o into the stack pointer |
| sp_o | output | 32 | Stack pointer after both pushes |
| done_o | output | 1 | Entry sequence completed |

## Verification
Two detection functions can apply to the same instruction. The delay-slot check can fire in the same cycle as trap or undefined decoding, for example when a trap or an undefined code lands right behind a delayed branch. The bench provokes this with directed pairs (delayed branch then trap, then undefined, then another delayed branch) and with random instruction streams in which delayed branches are frequent. It judges the outcome by the vector address that is read and by the stacked PC, which must be the latched branch target and not next_pc_i or cur_pc_i. Instructions presented during an entry are also checked: they must leave no trace in the slot record or the memory traffic.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_SR, ST_PUSH_PC, ST_RD_VEC, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    EXC_NONE, EXC_TRAP, EXC_SLOT, EXC_ILL
  } exc_kind_e;
endpackage

// File: rtl/exc_slot_track.sv
module exc_slot_track #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          flush_i,
  input  logic          dbranch_i,
  input  logic [AW-1:0] target_i,
  output logic          in_slot_o,
  output logic [AW-1:0] slot_target_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_o     <= 1'b0;
      slot_target_o <= '0;
    end else if (flush_i) begin
      in_slot_o <= 1'b0;
    end else if (issue_i) begin
      in_slot_o <= dbranch_i;
      if (dbranch_i) slot_target_o <= target_i;
    end
  end
endmodule

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          VW       = 8,
  parameter logic [VW-1:0] ILL_VEC  = 4,
  parameter logic [VW-1:0] SLOT_VEC = 6
) (
  input  logic          valid_i,
  input  logic          in_slot_i,
  input  logic          undef_i,
  input  logic          dbranch_i,
  input  logic          pc_wr_i,
  input  logic          trap_i,
  input  logic [VW-1:0] trap_vec_i,
  input  logic [AW-1:0] cur_pc_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic [AW-1:0] slot_target_i,
  output logic          hit_o,
  output exc_kind_e     kind_o,
  output logic [VW-1:0] vec_o,
  output logic [AW-1:0] save_pc_o
);
  logic slot_bad;
  assign slot_bad = in_slot_i & (undef_i | dbranch_i | pc_wr_i | trap_i);

  always_comb begin
    kind_o    = EXC_NONE;
    vec_o     = '0;
    save_pc_o = '0;
    if (valid_i) begin
      if (slot_bad) begin
        kind_o    = EXC_SLOT;
        vec_o     = SLOT_VEC;
        save_pc_o = slot_target_i;
      end else if (undef_i) begin
        kind_o    = EXC_ILL;
        vec_o     = ILL_VEC;
        save_pc_o = cur_pc_i;
      end else if (trap_i) begin
        kind_o    = EXC_TRAP;
        vec_o     = trap_vec_i;
        save_pc_o = next_pc_i;
      end
    end
  end

  assign hit_o = (kind_o != EXC_NONE);
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] save_pc_i,
  input  logic [DW-1:0] sr_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] vbase_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] WORD = AW'(4);

  seq_state_e    state_q;
  logic [DW-1:0] sr_q;
  logic [AW-1:0] pc_q, sp_q, va_q, hnd_q;
  logic [AW-1:0] vaddr;

  assign vaddr = vbase_i + {{(AW-VW-2){1'b0}}, vec_i, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      va_q    <= '0;
      hnd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PUSH_SR;
          sr_q    <= sr_i;
          pc_q    <= save_pc_i;
          sp_q    <= sp_i;
          va_q    <= vaddr;
        end
        ST_PUSH_SR: if (mem_ack_i) state_q <= ST_PUSH_PC;
        ST_PUSH_PC: if (mem_ack_i) state_q <= ST_RD_VEC;
        ST_RD_VEC: if (mem_ack_i) begin
          hnd_q   <= AW'(mem_rdata_i);
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_PUSH_SR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - WORD;
        mem_wdata_o = sr_q;
      end
      ST_PUSH_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q - 2 * WORD;
        mem_wdata_o = DW'(pc_q);
      end
      ST_RD_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = va_q;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign pc_o   = hnd_q;
  assign sp_o   = sp_q - 2 * WORD;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            VW       = 8,
  parameter logic [VW-1:0] ILL_VEC  = 4,
  parameter logic [VW-1:0] SLOT_VEC = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic          dec_undef_i,
  input  logic          dec_dbranch_i,
  input  logic          dec_pc_wr_i,
  input  logic          dec_trap_i,
  input  logic [VW-1:0] dec_trap_vec_i,
  input  logic [AW-1:0] cur_pc_i,
  input  logic [DW-1:0] cur_sr_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic [AW-1:0] br_target_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] vbase_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          stall_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          sp_wr_o,
  output logic [AW-1:0] sp_o,
  output logic          done_o
);
  logic          busy, accept, hit, in_slot;
  logic [AW-1:0] slot_target, save_pc;
  logic [VW-1:0] vec;
  exc_kind_e     kind;

  assign accept = dec_valid_i & ~busy;

  exc_slot_track #(.AW(AW)) u_slot (
    .clk_i, .rst_ni,
    .issue_i      (accept & ~hit),
    .flush_i      (hit),
    .dbranch_i    (dec_dbranch_i),
    .target_i     (br_target_i),
    .in_slot_o    (in_slot),
    .slot_target_o(slot_target)
  );

  exc_detect #(.AW(AW), .VW(VW), .ILL_VEC(ILL_VEC), .SLOT_VEC(SLOT_VEC)) u_det (
    .valid_i      (accept),
    .in_slot_i    (in_slot),
    .undef_i      (dec_undef_i),
    .dbranch_i    (dec_dbranch_i),
    .pc_wr_i      (dec_pc_wr_i),
    .trap_i       (dec_trap_i),
    .trap_vec_i   (dec_trap_vec_i),
    .cur_pc_i     (cur_pc_i),
    .next_pc_i    (next_pc_i),
    .slot_target_i(slot_target),
    .hit_o        (hit),
    .kind_o       (kind),
    .vec_o        (vec),
    .save_pc_o    (save_pc)
  );

  exc_seq_fsm #(.AW(AW), .DW(DW), .VW(VW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i    (hit),
    .vec_i      (vec),
    .save_pc_i  (save_pc),
    .sr_i       (cur_sr_i),
    .sp_i       (sp_i),
    .vbase_i    (vbase_i),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i,
    .busy_o     (busy),
    .done_o     (done_o),
    .pc_o       (pc_o),
    .sp_o       (sp_o)
  );

  assign stall_o   = busy | hit;
  assign pc_load_o = done_o;
  assign sp_wr_o   = done_o;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          stall_o,
  input logic          done_o,
  input logic          pc_load_o,
  input logic          sp_wr_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)) else $error("req hold"); // R9
  AST_FIRST_IS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> mem_we_o) else $error("first access"); // R2
  AST_DONE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_ack_i && !mem_we_o)) else $error("done order"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !pc_load_o && !sp_wr_o) else $error("done pulse"); // R7
  AST_STALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stall_o) else $error("stall at done"); // R8
  AST_NO_REQ_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> !mem_req_o && !done_o) else $error("req while free"); // R8
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_ack_i,
  .stall_o, .done_o, .pc_load_o, .sp_wr_o
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VBASE = 32'h0000_8000;
  localparam logic [31:0] HOFF  = 32'h0010_0000;
  localparam logic [7:0]  ILLV  = 8'd4;
  localparam logic [7:0]  SLOTV = 8'd6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic dec_valid_i = 0, dec_undef_i = 0, dec_dbranch_i = 0, dec_pc_wr_i = 0, dec_trap_i = 0;
  logic [7:0]  dec_trap_vec_i = 0;
  logic [31:0] cur_pc_i = 0, cur_sr_i = 0, next_pc_i = 0, br_target_i = 0, sp_i = 32'h0001_0000;
  logic [31:0] vbase_i = VBASE;
  logic        mem_req_o, mem_we_o, mem_ack_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = 0;
  logic        stall_o, pc_load_o, sp_wr_o, done_o;
  logic [31:0] pc_o, sp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni,
    .dec_valid_i, .dec_undef_i, .dec_dbranch_i, .dec_pc_wr_i, .dec_trap_i, .dec_trap_vec_i,
    .cur_pc_i, .cur_sr_i, .next_pc_i, .br_target_i, .sp_i, .vbase_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .stall_o, .pc_load_o, .pc_o, .sp_wr_o, .sp_o, .done_o
  );

  int unsigned total = 0, bad = 0;
  int unsigned log_n = 0;
  logic [31:0] la [4];
  logic [31:0] ld [4];
  logic        lw [4];
  bit          exp_slot = 0;
  logic [31:0] exp_tgt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: grant decided at negedge, consumed at next posedge
  always @(negedge clk) begin
    if (mem_req_o && ($urandom_range(0, 2) != 0)) begin
      if (log_n < 4) begin
        la[log_n] = mem_addr_o;
        ld[log_n] = mem_wdata_o;
        lw[log_n] = mem_we_o;
      end
      log_n++;
      mem_rdata_i = mem_addr_o + HOFF;
      mem_ack_i   = 1'b1;
    end else begin
      mem_ack_i   = 1'b0;
      mem_rdata_i = 32'hDEAD_BEEF;
    end
  end

  // 0 none, 1 trap, 2 slot, 3 illegal
  function automatic int classify(input bit und, input bit dbr, input bit pcw, input bit trp);
    if (exp_slot && (und || dbr || pcw || trp)) return 2;
    if (und) return 3;
    if (trp) return 1;
    return 0;
  endfunction

  task automatic run_instr(input bit und, input bit dbr, input bit pcw, input bit trp,
                           input logic [7:0] tv, input string tag);
    int kind;
    logic [31:0] pc, sp, sr, nx, tg, spc, va;
    bit seen;
    kind = classify(und, dbr, pcw, trp);
    pc = $urandom & 32'hFFFF_FFFE;
    nx = pc + 2;
    tg = $urandom & 32'hFFFF_FFFE;
    sr = $urandom;
    sp = ($urandom & 32'h00FF_FFFC) | 32'h0000_0100;
    @(negedge clk);
    log_n = 0;
    dec_valid_i = 1; dec_undef_i = und; dec_dbranch_i = dbr; dec_pc_wr_i = pcw;
    dec_trap_i = trp; dec_trap_vec_i = tv;
    cur_pc_i = pc; next_pc_i = nx; br_target_i = tg; cur_sr_i = sr; sp_i = sp;
    #1;
    chk(stall_o == (kind != 0), kind != 0 ? {tag, " R8 stall at detect"} : {tag, " R10 no stall"},
        {31'd0, stall_o}, {31'd0, kind != 0});
    if (kind == 0) begin
      exp_slot = dbr;
      if (dbr) exp_tgt = tg;
      @(negedge clk);
      dec_valid_i = 0;
      return;
    end
    case (kind)
      1: begin spc = nx;      va = VBASE + {22'd0, tv, 2'b00}; end
      2: begin spc = exp_tgt; va = VBASE + {22'd0, SLOTV, 2'b00}; end
      default: begin spc = pc; va = VBASE + {22'd0, ILLV, 2'b00}; end
    endcase
    exp_slot = 0;
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      // junk decode while stalled (R8: must be ignored)
      dec_valid_i = $urandom_range(0, 1); dec_undef_i = $urandom_range(0, 1);
      dec_dbranch_i = $urandom_range(0, 1); dec_trap_i = 0;
      cur_pc_i = $urandom; next_pc_i = $urandom; br_target_i = $urandom;
      sp_i = $urandom; cur_sr_i = $urandom;
      #1;
      if (!stall_o) chk(0, {tag, " R8 stall held"}, 0, 1);
      if (done_o) seen = 1;
    end
    dec_valid_i = 0;
    chk(seen, {tag, " R7 done seen"}, {31'd0, seen}, 1);
    if (!seen) return;
    chk(pc_load_o && sp_wr_o, {tag, " R7 load strobes"}, {30'd0, pc_load_o, sp_wr_o}, 3);
    chk(log_n == 3, {tag, " R2 access count"}, log_n, 3);
    chk(lw[0] && la[0] == sp - 4 && ld[0] == sr, {tag, " R2 sr push"}, la[0], sp - 4);
    chk(lw[1] && la[1] == sp - 8, {tag, " R2 pc push addr"}, la[1], sp - 8);
    chk(ld[1] == spc, kind == 1 ? {tag, " R3 stacked pc"} : kind == 2 ? {tag, " R4 stacked pc"}
        : {tag, " R5 stacked pc"}, ld[1], spc);
    chk(!lw[2] && la[2] == va, kind == 1 ? {tag, " R3 vector addr"} : kind == 2 ?
        {tag, " R4 vector addr"} : {tag, " R5 vector addr"}, la[2], va);
    chk(pc_o == va + HOFF, {tag, " R7 new pc"}, pc_o, va + HOFF);
    chk(sp_o == sp - 8, {tag, " R7 new sp"}, sp_o, sp - 8);
    @(negedge clk);
    chk(!done_o && !stall_o, {tag, " R7 pulse ends"}, {30'd0, done_o, stall_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7101);
    repeat (3) @(negedge clk);
    chk(!stall_o && !mem_req_o && !done_o && !pc_load_o && !sp_wr_o, "R1 reset outputs",
        {27'd0, stall_o, mem_req_o, done_o, pc_load_o, sp_wr_o}, 0);
    rst_ni = 1;
    run_instr(1, 0, 0, 0, 0, "R1 first undef general");
    run_instr(0, 0, 1, 1, 8'd33, "R3 trap");
    run_instr(0, 0, 1, 1, 8'd255, "R3 trap top vector");
    run_instr(0, 1, 1, 0, 0, "R6 dbranch");
    run_instr(0, 0, 1, 1, 8'd40, "R4 trap in slot");
    run_instr(1, 0, 0, 0, 0, "R6 undef after entry");
    run_instr(0, 1, 1, 0, 0, "R6 dbranch");
    run_instr(0, 0, 0, 0, 0, "R6 plain in slot");
    run_instr(1, 0, 0, 0, 0, "R6 undef after slot");
    run_instr(0, 1, 1, 0, 0, "R4 dbranch");
    run_instr(1, 0, 0, 0, 0, "R4 undef in slot");
    run_instr(0, 1, 1, 0, 0, "R4 dbranch");
    run_instr(0, 0, 1, 0, 0, "R4 cond branch in slot");
    run_instr(0, 1, 1, 0, 0, "R4 dbranch");
    run_instr(0, 1, 1, 0, 0, "R4 dbranch in slot");
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      run_instr(r == 0, r inside {[3:5]}, r inside {[1:6]}, r inside {[1:2]},
                8'($urandom), "rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule